// File: doc/BRIEF.md
# Multi-Lane Serial Data Shifter

This block converts between bytes on the system side and a clocked serial stream on the pin side. The stream runs over 1, 2, 4 or 8 data lanes, at single rate (one group of lane bits per serial clock cycle) or at double rate (one group on each serial clock edge). A requester picks the lane count, the rate, the direction, the serial clock idle level and a byte count, then pulses `start`. The block lowers chip select, moves exactly that many bytes and raises chip select again. The far end sends no acknowledgment, so the byte count alone sets the length of a transfer.

Bytes enter through a valid/ready pair when transmitting and leave through another valid/ready pair when receiving. Between bytes the engine waits, with the serial clock parked at its idle level, until the system side has a byte to send or has room for one it receives. Every serial half-period lasts `DIV` system clocks.

Top module: `mlane_shifter`

## Requirements
- R1: After reset, `cs_n` is 1, `done` is 0, `tx_ready` is 0, `rx_valid` is 0 and `sd_oe` is 0. From the second clock on, `sclk` follows `cfg_cpol`.
- R2: Whenever `cs_n` is 1, every bit of `sd_oe` and `sd_out` is 0, which leaves the lines floating.
- R3: At single rate with n lanes (lane code 0/1/2/3 = 1/2/4/8 lanes), each byte takes 8/n serial clock cycles. Each cycle carries one n-bit group, which the far end captures on the edge that leaves the idle level.
- R4: At double rate, each edge carries one group and a byte takes 8/(2n) cycles. With 8 lanes the byte is padded to one full cycle, and only the edge leaving idle carries data.
- R5: Bits within a byte go most significant first. In each n-bit group, lane n-1 holds the earliest bit and lane 0 the latest.
- R6: While chip select is active in a transmit transfer, `sd_oe[j]` is 1 exactly for lanes j < n. Lanes at or above n drive 0.
- R7: In a receive transfer, `sd_oe` stays 0 throughout. Received bytes, assembled in the order of R5, appear on `rx_data` with `rx_valid`.
- R8: `sclk` sits at the `cfg_cpol` level whenever chip select is inactive and between bytes.
- R9: A `start` with `cfg_len` = L > 0 lowers `cs_n` and moves exactly L bytes. On the clock that raises `cs_n`, `done` pulses for exactly one cycle. A `start` with L = 0 is ignored.
- R10: If no transmit byte is offered, or a received byte has not been taken, the engine holds before the next byte with `sclk` idle and `cs_n` low. An untaken `rx_valid` and its `rx_data` stay stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Begin a transfer with the current configuration |
| cfg_lanes | input | 2 | Lane code: 0=1, 1=2, 2=4, 3=8 lanes |
| cfg_ddr | input | 1 | 1 = double data rate |
| cfg_rx | input | 1 | 1 = receive, 0 = transmit |
| cfg_cpol | input | 1 | Serial clock idle level |
| cfg_len | input | LEN_W | Bytes in the transfer |
| done | output | 1 | One-cycle pulse at transfer end |
| tx_data | input | 8 | Byte to send |
| tx_valid | input | 1 | tx_data is offered |
| tx_ready | output | 1 | Engine takes tx_data this cycle |
| rx_data | output | 8 | Received byte |
| rx_valid | output | 1 | rx_data is valid |
| rx_ready | input | 1 | System takes rx_data |
| sclk | output | 1 | Serial clock |
| cs_n | output | 1 | Active-low chip select |
| sd_out | output | 8 | Per-lane output data |
| sd_oe | output | 8 | Per-lane output enable |
| sd_in | input | 8 | Per-lane input data |

## Verification
The checks assume that `cfg_*` stay constant while a transfer is in progress, and that `cfg_cpol` changes only while chip select is inactive. The idle-level property is measured against the previous cycle's `cfg_cpol`. The stimulus changes configuration only between transfers and waits a few idle cycles after changing polarity. The far-end model changes `sd_in` only on the falling system-clock edge after a capture edge, which keeps it stable at every sampling point. `start` is pulsed only while chip select is inactive.

// File: rtl/mls_pkg.sv
package mls_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_LOAD  = 2'd1,
        ST_SHIFT = 2'd2
    } st_e;

    localparam int BYTE_W = 8;
    localparam int LANE_MAX = 8;

endpackage

// File: rtl/mls_lane_map.sv
module mls_lane_map #(
    parameter int BW = 8
) (
    input  logic [1:0]    lanes,
    input  logic          drive,
    input  logic [BW-1:0] sr,
    input  logic [BW-1:0] sd_in,
    output logic [BW-1:0] out,
    output logic [BW-1:0] oe,
    output logic [BW-1:0] sr_tx,
    output logic [BW-1:0] sr_rx
);
    localparam int SH_W = $clog2(BW) + 1;

    logic [SH_W-1:0] n;
    logic [BW-1:0]   mask;

    assign n = SH_W'(1) << lanes;

    for (genvar j = 0; j < BW; j++) begin : g_mask
        assign mask[j] = (SH_W'(j) < n);
    end

    assign out   = drive ? ((sr >> (SH_W'(BW) - n)) & mask) : '0;
    assign oe    = drive ? mask : '0;
    assign sr_tx = sr << n;
    assign sr_rx = (sr << n) | (sd_in & mask);
endmodule

// File: rtl/mls_byte_timer.sv
module mls_byte_timer (
    input  logic [1:0] lanes,
    input  logic       ddr,
    input  logic [3:0] ph,
    output logic       last,
    output logic       sample,
    output logic       advance
);
    logic [3:0] groups;
    logic [4:0] halves;

    always_comb begin
        groups = 4'd8 >> lanes;
        if (ddr) begin
            halves  = (groups < 4'd2) ? 5'd2 : {1'b0, groups};
            sample  = (ph < groups);
            advance = (ph < groups);
        end else begin
            halves  = {groups, 1'b0};
            sample  = ~ph[0];
            advance = ph[0];
        end
        last = ({1'b0, ph} == halves - 5'd1);
    end
endmodule

// File: rtl/mlane_shifter.sv
module mlane_shifter #(
    parameter int DIV   = 2,
    parameter int LEN_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [1:0]       cfg_lanes,
    input  logic             cfg_ddr,
    input  logic             cfg_rx,
    input  logic             cfg_cpol,
    input  logic [LEN_W-1:0] cfg_len,
    output logic             done,
    input  logic [7:0]       tx_data,
    input  logic             tx_valid,
    output logic             tx_ready,
    output logic [7:0]       rx_data,
    output logic             rx_valid,
    input  logic             rx_ready,
    output logic             sclk,
    output logic             cs_n,
    output logic [7:0]       sd_out,
    output logic [7:0]       sd_oe,
    input  logic [7:0]       sd_in
);
    import mls_pkg::*;

    localparam int DIV_W = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [DIV_W-1:0] DIV_END = DIV_W'(DIV - 1);

    typedef struct packed {
        st_e              st;
        logic             cs_n;
        logic             sclk;
        logic             done;
        logic [7:0]       sr;
        logic [3:0]       ph;
        logic [DIV_W-1:0] div;
        logic [LEN_W-1:0] left;
        logic [1:0]       lanes;
        logic             ddr;
        logic             rx;
        logic             cpol;
        logic             rxv;
        logic [7:0]       rxd;
    } regs_t;

    regs_t q, d;

    logic       t_last, t_sample, t_adv;
    logic [7:0] map_out, map_oe, sr_tx, sr_rx;
    logic       drive;
    logic       mode_rx, mode_ddr;
    logic [1:0] mode_lanes;

    assign drive = ~q.cs_n & ~q.rx;

    mls_byte_timer u_timer (
        .lanes   (q.lanes),
        .ddr     (q.ddr),
        .ph      (q.ph),
        .last    (t_last),
        .sample  (t_sample),
        .advance (t_adv)
    );

    mls_lane_map #(.BW(BYTE_W)) u_map (
        .lanes (q.lanes),
        .drive (drive),
        .sr    (q.sr),
        .sd_in (sd_in),
        .out   (map_out),
        .oe    (map_oe),
        .sr_tx (sr_tx),
        .sr_rx (sr_rx)
    );

    always_comb begin
        d      = q;
        d.done = 1'b0;
        if (q.rxv && rx_ready) d.rxv = 1'b0;
        unique case (q.st)
            ST_IDLE: begin
                d.sclk = cfg_cpol;
                if (start && cfg_len != '0) begin
                    d.lanes = cfg_lanes;
                    d.ddr   = cfg_ddr;
                    d.rx    = cfg_rx;
                    d.cpol  = cfg_cpol;
                    d.left  = cfg_len;
                    d.cs_n  = 1'b0;
                    d.st    = ST_LOAD;
                end
            end
            ST_LOAD: begin
                if (!q.rx && tx_valid) begin
                    d.sr  = tx_data;
                    d.st  = ST_SHIFT;
                    d.ph  = '0;
                    d.div = '0;
                end else if (q.rx && (!q.rxv || rx_ready)) begin
                    d.sr  = '0;
                    d.st  = ST_SHIFT;
                    d.ph  = '0;
                    d.div = '0;
                end
            end
            ST_SHIFT: begin
                if (q.div == DIV_END) begin
                    d.div  = '0;
                    d.sclk = ~q.sclk;
                    if (q.rx && t_sample)      d.sr = sr_rx;
                    else if (!q.rx && t_adv)   d.sr = sr_tx;
                    if (t_last) begin
                        d.left = q.left - LEN_W'(1);
                        if (q.rx) begin
                            d.rxd = d.sr;
                            d.rxv = 1'b1;
                        end
                        if (q.left == LEN_W'(1)) begin
                            d.cs_n = 1'b1;
                            d.done = 1'b1;
                            d.st   = ST_IDLE;
                        end else begin
                            d.st = ST_LOAD;
                        end
                    end else begin
                        d.ph = q.ph + 4'd1;
                    end
                end else begin
                    d.div = q.div + DIV_W'(1);
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.cs_n <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign done       = q.done;
    assign tx_ready   = (q.st == ST_LOAD) && !q.rx;
    assign rx_data    = q.rxd;
    assign rx_valid   = q.rxv;
    assign sclk       = q.sclk;
    assign cs_n       = q.cs_n;
    assign sd_out     = map_out;
    assign sd_oe      = map_oe;
    assign mode_rx    = q.rx;
    assign mode_ddr   = q.ddr;
    assign mode_lanes = q.lanes;
endmodule

// File: rtl/mls_checker.sv
module mls_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       cs_n,
    input logic       sclk,
    input logic       cfg_cpol,
    input logic [7:0] sd_oe,
    input logic [7:0] sd_out,
    input logic       done,
    input logic       rx_valid,
    input logic       rx_ready,
    input logic [7:0] rx_data,
    input logic       tx_ready,
    input logic       mode_rx,
    input logic       mode_ddr,
    input logic [1:0] mode_lanes
);
    logic armed;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) armed <= 1'b0;
        else        armed <= 1'b1;
    end

    p_oe_released_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> (sd_oe == 8'h00));

    p_out_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> (sd_out == 8'h00));

    p_tx_lane_count_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && !mode_rx) |-> ($countones(sd_oe) == (1 << mode_lanes)));

    p_rx_no_drive_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && mode_rx) |-> (sd_oe == 8'h00));

    p_sclk_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && cs_n && $past(cs_n)) |-> (sclk == $past(cfg_cpol)));

    p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_done_ends_select_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && done) |-> (cs_n && !$past(cs_n)));

    p_rx_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && !rx_ready) |=> (rx_valid && $stable(rx_data)));

    p_tx_ready_selected_r10: assert property (@(posedge clk) disable iff (!rst_n)
        tx_ready |-> (!cs_n && !mode_rx && (mode_ddr || !mode_ddr)));
endmodule

bind mlane_shifter mls_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cs_n       (cs_n),
    .sclk       (sclk),
    .cfg_cpol   (cfg_cpol),
    .sd_oe      (sd_oe),
    .sd_out     (sd_out),
    .done       (done),
    .rx_valid   (rx_valid),
    .rx_ready   (rx_ready),
    .rx_data    (rx_data),
    .tx_ready   (tx_ready),
    .mode_rx    (mode_rx),
    .mode_ddr   (mode_ddr),
    .mode_lanes (mode_lanes)
);

// File: tb/sim_mlane_shifter.sv
`timescale 1ns/1ps
module sim_mlane_shifter;
    localparam int LEN_W = 8;
    localparam int NVEC  = 12;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [1:0] cfg_lanes = 2'd0;
    logic cfg_ddr = 1'b0, cfg_rx = 1'b0, cfg_cpol = 1'b0;
    logic [LEN_W-1:0] cfg_len = '0;
    logic done;
    logic [7:0] tx_data = 8'h00;
    logic tx_valid = 1'b0;
    logic tx_ready;
    logic [7:0] rx_data;
    logic rx_valid;
    logic rx_ready = 1'b1;
    logic sclk, cs_n;
    logic [7:0] sd_out, sd_oe;
    logic [7:0] sd_in;

    always #10 clk = ~clk;

    mlane_shifter #(.DIV(2), .LEN_W(LEN_W)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .cfg_lanes(cfg_lanes),
        .cfg_ddr(cfg_ddr), .cfg_rx(cfg_rx), .cfg_cpol(cfg_cpol), .cfg_len(cfg_len),
        .done(done), .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
        .rx_data(rx_data), .rx_valid(rx_valid), .rx_ready(rx_ready),
        .sclk(sclk), .cs_n(cs_n), .sd_out(sd_out), .sd_oe(sd_oe), .sd_in(sd_in)
    );

    // {lanes, ddr, rx, cpol, len[3:0], seed}
    localparam logic [16:0] VEC [NVEC] = '{
        {2'd0, 1'b0, 1'b0, 1'b0, 4'd2, 8'hA5},
        {2'd1, 1'b0, 1'b0, 1'b1, 4'd2, 8'h3C},
        {2'd2, 1'b0, 1'b0, 1'b0, 4'd3, 8'h96},
        {2'd3, 1'b0, 1'b0, 1'b1, 4'd2, 8'hE1},
        {2'd0, 1'b1, 1'b0, 1'b0, 4'd2, 8'h5A},
        {2'd2, 1'b1, 1'b0, 1'b1, 4'd2, 8'hC3},
        {2'd3, 1'b1, 1'b0, 1'b0, 4'd3, 8'h7E},
        {2'd0, 1'b0, 1'b1, 1'b1, 4'd2, 8'hB4},
        {2'd1, 1'b1, 1'b1, 1'b0, 4'd2, 8'h69},
        {2'd3, 1'b1, 1'b1, 1'b1, 4'd2, 8'hD2},
        {2'd2, 1'b0, 1'b1, 1'b0, 4'd3, 8'h18},
        {2'd1, 1'b1, 1'b0, 1'b0, 4'd1, 8'h81}
    };

    int n_total = 0, n_fail = 0, cycles = 0;

    // far-end / monitor state
    logic       mon_en = 1'b0;
    logic       cur_rx = 1'b0, cur_ddr = 1'b0, cur_cpol = 1'b0;
    int         cur_n = 1;
    logic [7:0] expb [16];
    logic [7:0] gotb [16];
    int         bcnt = 0, grp = 0, lead_cnt = 0, done_cnt = 0, rbyte = 0, rgrp = 0;
    logic [7:0] acc = 8'h00;
    logic       prev_sclk = 1'b0;
    logic [7:0] prev_out = 8'h00, prev_oe = 8'h00;
    logic       oe_bad = 1'b0;
    logic [7:0] sd_in_r = 8'h00;

    assign sd_in = sd_in_r;

    function automatic logic [7:0] lmask(input int n);
        return 8'((1 << n) - 1);
    endfunction

    function automatic logic [7:0] group_of(input logic [7:0] b, input int n, input int g);
        return 8'((b >> (8 - n * (g + 1)))) & lmask(n);
    endfunction

    task automatic check(input logic ok, input string tag, input int act, input int exp);
        n_total++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles == 150000) begin
            n_total++;
            n_fail++;
            $display("FAIL R9 watchdog: actual %0d expected %0d", cycles, 0);
            $display("%0d/%0d checks passed", n_total - n_fail, n_total);
            $finish;
        end
    end

    always @(negedge clk) begin
        if (mon_en) begin
            logic edge_seen, lead, dedge;
            edge_seen = (sclk != prev_sclk);
            lead      = edge_seen && (sclk != cur_cpol);
            if (lead) lead_cnt++;
            if (cur_ddr) dedge = (cur_n == 8) ? lead : edge_seen;
            else         dedge = lead;
            if (done) done_cnt++;
            if (!cs_n && cur_rx && sd_oe != 8'h00) oe_bad = 1'b1;
            if (!cs_n && !cur_rx && (sd_oe != lmask(cur_n) || (sd_out & ~lmask(cur_n)) != 8'h00))
                oe_bad = 1'b1;
            if (dedge) begin
                if (!cur_rx) begin
                    acc = 8'((acc << cur_n) | (prev_out & lmask(cur_n)));
                    grp++;
                    if (grp == 8 / cur_n) begin
                        gotb[bcnt] = acc;
                        bcnt++;
                        grp = 0;
                    end
                end else begin
                    rgrp++;
                    if (rgrp == 8 / cur_n) begin
                        rgrp = 0;
                        rbyte++;
                    end
                end
            end
            if (cur_rx && rx_valid && rx_ready) begin
                gotb[bcnt] = rx_data;
                bcnt++;
            end
            sd_in_r = (cur_rx && rbyte < 16) ? group_of(expb[rbyte], cur_n, rgrp) : 8'h00;
        end
        prev_sclk = sclk;
        prev_out  = sd_out;
        prev_oe   = sd_oe;
    end

    task automatic run_xfer(input logic [1:0] lanes, input logic ddr, input logic rx,
                            input logic cpol, input int len, input logic [7:0] seed,
                            input logic stall);
        int n, cyc, wait_cnt;
        logic bytes_ok;
        n = 1 << lanes;
        cyc = ddr ? ((8 / (2 * n) < 1) ? 1 : 8 / (2 * n)) : 8 / n;
        @(negedge clk);
        cfg_lanes = lanes; cfg_ddr = ddr; cfg_rx = rx; cfg_cpol = cpol;
        cfg_len = LEN_W'(len);
        for (int i = 0; i < len; i++) expb[i] = 8'(seed + i * 8'h3B);
        repeat (3) @(negedge clk);
        cur_rx = rx; cur_ddr = ddr; cur_cpol = cpol; cur_n = n;
        bcnt = 0; grp = 0; acc = 8'h00; lead_cnt = 0; done_cnt = 0;
        rbyte = 0; rgrp = 0; oe_bad = 1'b0;
        rx_ready = !(rx && stall);
        mon_en = 1'b1;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (!rx) begin
            for (int i = 0; i < len; i++) begin
                if (stall && i == 1) begin
                    tx_valid = 1'b0;
                    repeat (30) @(negedge clk);
                    check(!cs_n && sclk == cpol && tx_ready, "R10 tx stall holds engine",
                          {cs_n, sclk, tx_ready}, {1'b0, cpol, 1'b1});
                end
                tx_data = expb[i];
                tx_valid = 1'b1;
                wait_cnt = 0;
                while (!tx_ready && wait_cnt < 2000) begin
                    @(negedge clk);
                    wait_cnt++;
                end
                @(negedge clk);
            end
            tx_valid = 1'b0;
        end else if (stall) begin
            repeat (60) @(negedge clk);
            check(rx_valid && !cs_n && sclk == cpol && rx_data == expb[0],
                  "R10 rx stall holds byte", {rx_valid, cs_n, rx_data}, {1'b1, 1'b0, expb[0]});
            rx_ready = 1'b1;
        end
        wait_cnt = 0;
        while (done_cnt == 0 && wait_cnt < 5000) begin
            @(negedge clk);
            wait_cnt++;
        end
        repeat (3) @(negedge clk);
        mon_en = 1'b0;
        bytes_ok = 1'b1;
        for (int i = 0; i < len; i++) if (gotb[i] !== expb[i]) bytes_ok = 1'b0;
        check(bcnt == len && done_cnt == 1 && cs_n, "R9 byte count and done pulse",
              bcnt * 16 + done_cnt, len * 16 + 1);
        check(bytes_ok, "R5 byte order", gotb[0], expb[0]);
        if (ddr) check(lead_cnt == len * cyc, "R4 cycles per byte double rate", lead_cnt, len * cyc);
        else     check(lead_cnt == len * cyc, "R3 cycles per byte single rate", lead_cnt, len * cyc);
        if (rx) check(!oe_bad, "R7 no drive while receiving", oe_bad, 0);
        else    check(!oe_bad, "R6 active lanes only", oe_bad, 0);
        check(sd_oe == 8'h00 && sd_out == 8'h00, "R2 released after transfer", sd_oe, 0);
        check(sclk == cpol, "R8 idle level after transfer", sclk, cpol);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(cs_n && !done && !tx_ready && !rx_valid && sd_oe == 8'h00,
              "R1 reset state", {cs_n, done, tx_ready, rx_valid, sd_oe}, {4'b1000, 8'h00});
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(sclk == 1'b0 && cs_n, "R1 idle after reset", sclk, 0);
        cfg_cpol = 1'b1;
        repeat (2) @(negedge clk);
        check(sclk == 1'b1, "R8 idle follows polarity", sclk, 1);

        for (int v = 0; v < NVEC; v++) begin
            logic [16:0] e;
            e = VEC[v];
            run_xfer(e[16:15], e[14], e[13], e[12], int'(e[11:8]), e[7:0], 1'b0);
        end

        // zero length start is ignored (R9)
        @(negedge clk);
        cfg_len = '0; cfg_rx = 1'b0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (10) @(negedge clk);
        check(cs_n && !tx_ready, "R9 zero length ignored", cs_n, 1);

        // flow-control stalls (R10)
        run_xfer(2'd1, 1'b0, 1'b0, 1'b0, 2, 8'h4D, 1'b1);
        run_xfer(2'd1, 1'b0, 1'b1, 1'b1, 2, 8'hF0, 1'b1);

        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end
endmodule